// File: doc/BRIEF.md
# Aliased Special Register Bank

This block holds the special-purpose state of a big-number arithmetic engine and serves it through two access ports in parallel. A 32-bit port, addressed with 12 bits, does read-replace and read-OR accesses. A 256-bit port, addressed with a small index, does plain reads and writes. The arithmetic flag groups, a 256-bit modulus and a 256-bit accumulator live here. The narrow port reaches the modulus as eight 32-bit slices. It reaches the flags through three views: each group on its own, and both groups together.

Random numbers are not stored in the bank. Reads of the high-quality random source pass through to an external cache, and the requester is held while that cache has no valid entry. A read that succeeds takes the entry out of the cache. Reads of the low-quality random source pass straight through and never wait. A write to a dedicated narrow address asks the cache to refill. Every writable register returns to zero when an operation starts. Accesses to addresses that are not mapped are reported on a pulse output.

Top module: `bnsr_bank`

## Requirements
- R1: A high `op_start_i` sets the flags, MOD and ACC to zero from the next cycle on. This wins over any write in the same cycle. A low `rst_ni` also sets them to zero.
- R2: On the narrow port, `csr_op_i`=0 replaces the addressed value with `csr_wdata_i`, and `csr_op_i`=1 ORs `csr_wdata_i` into it. In both cases `csr_rdata_o` shows the value from before the access in the same cycle, and the update is visible from the next cycle.
- R3: Narrow address 0x7D0+k, for k from 0 to 7, reads and writes bits [32k+31:32k] of MOD, which is wide index 0.
- R4: Narrow address 0x7C0 is flag group 0, held in flag bits [3:0]. Address 0x7C1 is flag group 1, held in flag bits [7:4]. Both appear in bits [3:0] of the data word. Address 0x7C8 shows all eight flag bits in [7:0]. Upper data bits read as zero, and written upper bits are dropped.
- R5: Wide index 0 (MOD) and index 2 (ACC) are read-write. A write with `wide_we_i`=1 replaces all 256 bits. Reads are combinational.
- R6: Writes to narrow 0xFC0 or 0xFC1, or to wide index 1 or 3, change no register and do not raise `illegal_o`.
- R7: An accepted access to narrow 0x7D8 raises `rnd_prefetch_o` for exactly one cycle, in the cycle after the access. A read of 0x7D8 returns 0.
- R8: Any narrow access to 0xFC0, and any wide read of index 1, raises the matching stall output while `rnd_valid_i` is low. During the stall nothing is written and `rnd_ack_o` stays low. Once `rnd_valid_i` is high, the access returns `rnd_data_i` (the low 32 bits on the narrow port) and pulses `rnd_ack_o` in that same cycle.
- R9: Narrow 0xFC1 and wide index 3 return `urnd_data_i` (the low 32 bits on the narrow port), never stall and never raise `rnd_ack_o`.
- R10: A request to an unmapped narrow address, or to a wide index of 4 or above, raises `illegal_o` for one cycle in the next cycle. Unmapped reads return zero.
- R11: When both ports write MOD in the same cycle, all 256 bits take the wide port's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_start_i | input | 1 | Operation-start pulse, clears writable registers |
| csr_req_i | input | 1 | Narrow port request |
| csr_op_i | input | 1 | 0 = read-replace, 1 = read-OR |
| csr_addr_i | input | 12 | Narrow address |
| csr_wdata_i | input | 32 | Narrow write data |
| csr_rdata_o | output | 32 | Narrow read data (value before the access) |
| csr_stall_o | output | 1 | Narrow access held, waiting for random data |
| wide_req_i | input | 1 | Wide port request |
| wide_we_i | input | 1 | Wide write enable |
| wide_idx_i | input | WIDX_W | Wide register index |
| wide_wdata_i | input | 256 | Wide write data |
| wide_rdata_o | output | 256 | Wide read data |
| wide_stall_o | output | 1 | Wide read held, waiting for random data |
| rnd_valid_i | input | 1 | Random cache holds a valid entry |
| rnd_data_i | input | 256 | Cached random value |
| urnd_data_i | input | 256 | Low-quality random value |
| rnd_ack_o | output | 1 | Cached entry consumed this cycle |
| rnd_prefetch_o | output | 1 | Cache refill request pulse |
| illegal_o | output | 1 | Unmapped access seen in the previous cycle |

## Verification
The assertions assume that a requester holds its address, operation and data steady while it is stalled. They also assume that `rnd_valid_i` drops only after the cycle in which `rnd_ack_o` consumed the entry, and that `op_start_i` stays low during access sequences whose results are being compared. The stimulus keeps to these rules. It drives each access for the full duration of its stall and changes the random inputs only between accesses. It pulses `op_start_i` only in the directed clear tests, where the expected result is all zeros. The random phase draws narrow addresses from the mapped set mixed with arbitrary 12-bit values, and wide indices over the whole index range.

// File: rtl/bnsr_pkg.sv
package bnsr_pkg;
  parameter int unsigned CSR_W      = 32;
  parameter int unsigned WIDE_W     = 256;
  parameter int unsigned CSR_ADDR_W = 12;
  parameter int unsigned FLAG_GRP_W = 4;
  parameter int unsigned FLAG_GRPS  = 2;
  parameter int unsigned WIDE_REGS  = 4;

  localparam int unsigned MOD_LANES  = WIDE_W / CSR_W;
  localparam int unsigned MOD_LANE_W = $clog2(MOD_LANES);
  localparam int unsigned FLAG_W     = FLAG_GRP_W * FLAG_GRPS;

  // The modulus slice base is aligned so that the low bits select the slice.
  localparam logic [CSR_ADDR_W-1:0] A_GRP0     = 12'h7C0;
  localparam logic [CSR_ADDR_W-1:0] A_GRP1     = 12'h7C1;
  localparam logic [CSR_ADDR_W-1:0] A_ALLFLAGS = 12'h7C8;
  localparam logic [CSR_ADDR_W-1:0] A_MODBASE  = 12'h7D0;
  localparam logic [CSR_ADDR_W-1:0] A_REFILL   = 12'h7D8;
  localparam logic [CSR_ADDR_W-1:0] A_RNDQ     = 12'hFC0;
  localparam logic [CSR_ADDR_W-1:0] A_RNDF     = 12'hFC1;

  typedef enum logic {
    OP_REPLACE = 1'b0,
    OP_ORIN    = 1'b1
  } csr_op_e;

  typedef enum logic [1:0] {
    WX_MOD  = 2'd0,
    WX_RNDQ = 2'd1,
    WX_ACC  = 2'd2,
    WX_RNDF = 2'd3
  } wide_idx_e;

  typedef struct packed {
    logic                  grp0;
    logic                  grp1;
    logic                  allflags;
    logic                  mod;
    logic [MOD_LANE_W-1:0] mod_lane;
    logic                  refill;
    logic                  rndq;
    logic                  rndf;
    logic                  legal;
  } csr_sel_t;
endpackage

// File: rtl/bnsr_csr_dec.sv
module bnsr_csr_dec
  import bnsr_pkg::*;
(
  input  logic [CSR_ADDR_W-1:0] addr_i,
  output csr_sel_t              sel_o
);
  localparam int unsigned SLICE_SHIFT = MOD_LANE_W;

  always_comb begin
    sel_o          = '0;
    sel_o.grp0     = (addr_i == A_GRP0);
    sel_o.grp1     = (addr_i == A_GRP1);
    sel_o.allflags = (addr_i == A_ALLFLAGS);
    sel_o.mod      = ((addr_i >> SLICE_SHIFT) == (A_MODBASE >> SLICE_SHIFT));
    sel_o.mod_lane = addr_i[MOD_LANE_W-1:0];
    sel_o.refill   = (addr_i == A_REFILL);
    sel_o.rndq     = (addr_i == A_RNDQ);
    sel_o.rndf     = (addr_i == A_RNDF);
    sel_o.legal    = sel_o.grp0 | sel_o.grp1 | sel_o.allflags | sel_o.mod |
                     sel_o.refill | sel_o.rndq | sel_o.rndf;
  end
endmodule

// File: rtl/bnsr_lane_reg.sv
module bnsr_lane_reg #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic [LANES-1:0]        lane_we_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] q_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic              en;
    logic [LANE_W-1:0] d, q;

    always_comb begin
      en = clr_i | lane_we_i[l];
      d  = clr_i ? '0 : wdata_i[l*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= d;
    end

    assign q_o[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/bnsr_bank.sv
module bnsr_bank
  import bnsr_pkg::*;
#(
  parameter int unsigned WIDX_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  op_start_i,
  input  logic                  csr_req_i,
  input  logic                  csr_op_i,
  input  logic [CSR_ADDR_W-1:0] csr_addr_i,
  input  logic [CSR_W-1:0]      csr_wdata_i,
  output logic [CSR_W-1:0]      csr_rdata_o,
  output logic                  csr_stall_o,
  input  logic                  wide_req_i,
  input  logic                  wide_we_i,
  input  logic [WIDX_W-1:0]     wide_idx_i,
  input  logic [WIDE_W-1:0]     wide_wdata_i,
  output logic [WIDE_W-1:0]     wide_rdata_o,
  output logic                  wide_stall_o,
  input  logic                  rnd_valid_i,
  input  logic [WIDE_W-1:0]     rnd_data_i,
  input  logic [WIDE_W-1:0]     urnd_data_i,
  output logic                  rnd_ack_o,
  output logic                  rnd_prefetch_o,
  output logic                  illegal_o
);
  localparam logic [WIDX_W-1:0] WX_LAST = WIDX_W'(WIDE_REGS - 1);

  csr_sel_t            csel;
  logic [FLAG_W-1:0]   flags_q;
  logic [WIDE_W-1:0]   mod_q, acc_q;
  logic [CSR_W-1:0]    csr_old, csr_new;
  logic                csr_go, wide_go, wide_legal;
  logic                w_mod, w_rndq, w_acc, w_rndf, wide_rd_rndq;
  logic [FLAG_GRPS-1:0] flag_we;
  logic [FLAG_W-1:0]   flag_wd;
  logic [MOD_LANES-1:0] mod_we;
  logic [WIDE_W-1:0]   mod_wd;
  logic                acc_we;
  logic                refill_d, refill_q, ill_d, ill_q;

  bnsr_csr_dec u_dec (.addr_i(csr_addr_i), .sel_o(csel));

  // Wide index decode and random stall
  always_comb begin
    wide_legal   = (wide_idx_i <= WX_LAST);
    w_mod        = wide_legal & (wide_idx_i == WIDX_W'(WX_MOD));
    w_rndq       = wide_legal & (wide_idx_i == WIDX_W'(WX_RNDQ));
    w_acc        = wide_legal & (wide_idx_i == WIDX_W'(WX_ACC));
    w_rndf       = wide_legal & (wide_idx_i == WIDX_W'(WX_RNDF));
    wide_rd_rndq = wide_req_i & ~wide_we_i & w_rndq;
    csr_stall_o  = csr_req_i & csel.rndq & ~rnd_valid_i;
    wide_stall_o = wide_rd_rndq & ~rnd_valid_i;
    csr_go       = csr_req_i & ~csr_stall_o;
    wide_go      = wide_req_i & ~wide_stall_o;
    rnd_ack_o    = (csr_go & csel.rndq) | (wide_go & wide_rd_rndq);
  end

  // Narrow read view and read-modify value
  always_comb begin
    csr_old = '0;
    if (csel.grp0)          csr_old = CSR_W'(flags_q[FLAG_GRP_W-1:0]);
    else if (csel.grp1)     csr_old = CSR_W'(flags_q[FLAG_W-1:FLAG_GRP_W]);
    else if (csel.allflags) csr_old = CSR_W'(flags_q);
    else if (csel.mod)      csr_old = mod_q[csel.mod_lane*CSR_W +: CSR_W];
    else if (csel.rndq)     csr_old = rnd_data_i[CSR_W-1:0];
    else if (csel.rndf)     csr_old = urnd_data_i[CSR_W-1:0];
    csr_new     = (csr_op_e'(csr_op_i) == OP_ORIN) ? (csr_old | csr_wdata_i) : csr_wdata_i;
    csr_rdata_o = csr_old;
  end

  // Wide read view
  always_comb begin
    wide_rdata_o = '0;
    if (w_mod)       wide_rdata_o = mod_q;
    else if (w_rndq) wide_rdata_o = rnd_data_i;
    else if (w_acc)  wide_rdata_o = acc_q;
    else if (w_rndf) wide_rdata_o = urnd_data_i;
  end

  // Flag storage: two groups, single or joint view
  always_comb begin
    flag_we[0] = csr_go & (csel.grp0 | csel.allflags);
    flag_we[1] = csr_go & (csel.grp1 | csel.allflags);
    flag_wd    = csel.allflags ? csr_new[FLAG_W-1:0]
                               : {FLAG_GRPS{csr_new[FLAG_GRP_W-1:0]}};
  end

  bnsr_lane_reg #(.LANE_W(FLAG_GRP_W), .LANES(FLAG_GRPS)) u_flags (
    .clk_i, .rst_ni, .clr_i(op_start_i),
    .lane_we_i(flag_we), .wdata_i(flag_wd), .q_o(flags_q)
  );

  // Modulus: wide port takes every slice, narrow port one slice
  for (genvar k = 0; k < MOD_LANES; k++) begin : g_mod_slice
    assign mod_we[k] = (wide_go & wide_we_i & w_mod) |
                       (csr_go & csel.mod & (csel.mod_lane == MOD_LANE_W'(k)));
    assign mod_wd[k*CSR_W +: CSR_W] = (wide_go & wide_we_i & w_mod)
                                      ? wide_wdata_i[k*CSR_W +: CSR_W] : csr_new;
  end

  bnsr_lane_reg #(.LANE_W(CSR_W), .LANES(MOD_LANES)) u_mod (
    .clk_i, .rst_ni, .clr_i(op_start_i),
    .lane_we_i(mod_we), .wdata_i(mod_wd), .q_o(mod_q)
  );

  assign acc_we = wide_go & wide_we_i & w_acc;

  bnsr_lane_reg #(.LANE_W(WIDE_W), .LANES(1)) u_acc (
    .clk_i, .rst_ni, .clr_i(op_start_i),
    .lane_we_i(acc_we), .wdata_i(wide_wdata_i), .q_o(acc_q)
  );

  // Registered pulses
  always_comb begin
    refill_d = csr_go & csel.refill;
    ill_d    = (csr_req_i & ~csel.legal) | (wide_req_i & ~wide_legal);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      refill_q <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      refill_q <= refill_d;
      ill_q    <= ill_d;
    end
  end

  assign rnd_prefetch_o = refill_q;
  assign illegal_o      = ill_q;
endmodule

// File: rtl/bnsr_bank_chk.sv
module bnsr_bank_chk
  import bnsr_pkg::*;
#(
  parameter int unsigned WIDX_W = 3
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  op_start_i,
  input logic                  csr_req_i,
  input logic [CSR_ADDR_W-1:0] csr_addr_i,
  input logic [CSR_W-1:0]      csr_rdata_o,
  input logic                  csr_stall_o,
  input logic                  wide_req_i,
  input logic                  wide_we_i,
  input logic [WIDX_W-1:0]     wide_idx_i,
  input logic                  wide_stall_o,
  input logic                  rnd_valid_i,
  input logic                  rnd_ack_o,
  input logic                  rnd_prefetch_o,
  input logic                  illegal_o,
  input logic [FLAG_W-1:0]     flags_q,
  input logic [WIDE_W-1:0]     mod_q,
  input logic [WIDE_W-1:0]     acc_q
);
  a_r1_clear_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |=> (flags_q == '0 && mod_q == '0 && acc_q == '0));

  a_r8_csr_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_addr_i == A_RNDQ && !rnd_valid_i) |-> (csr_stall_o && !rnd_ack_o));

  a_r8_wide_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_req_i && !wide_we_i && wide_idx_i == WIDX_W'(1) && !rnd_valid_i) |-> (wide_stall_o && !rnd_ack_o));

  a_r8_ack_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_ack_o |-> rnd_valid_i);

  a_r7_refill_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_addr_i == A_REFILL) |-> (csr_rdata_o == '0));

  a_r7_refill_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_req_i && csr_addr_i == A_REFILL) |=> rnd_prefetch_o);

  a_r6_ro_wide_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_req_i && wide_we_i && (wide_idx_i == WIDX_W'(1) || wide_idx_i == WIDX_W'(3))
     && !csr_req_i && !op_start_i)
    |=> ($stable(mod_q) && $stable(acc_q) && $stable(flags_q) && !illegal_o));

  a_r10_wide_illegal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wide_req_i && wide_idx_i > WIDX_W'(3)) |=> illegal_o);
endmodule

bind bnsr_bank bnsr_bank_chk #(.WIDX_W(WIDX_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_start_i(op_start_i),
  .csr_req_i(csr_req_i), .csr_addr_i(csr_addr_i), .csr_rdata_o(csr_rdata_o),
  .csr_stall_o(csr_stall_o), .wide_req_i(wide_req_i), .wide_we_i(wide_we_i),
  .wide_idx_i(wide_idx_i), .wide_stall_o(wide_stall_o), .rnd_valid_i(rnd_valid_i),
  .rnd_ack_o(rnd_ack_o), .rnd_prefetch_o(rnd_prefetch_o), .illegal_o(illegal_o),
  .flags_q(flags_q), .mod_q(mod_q), .acc_q(acc_q)
);

// File: tb/test_bnsr_bank.sv
module test_bnsr_bank;
  localparam int WX = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         op_start;
  logic         csr_req, csr_op;
  logic [11:0]  csr_addr;
  logic [31:0]  csr_wdata, csr_rdata;
  logic         csr_stall;
  logic         wide_req, wide_we;
  logic [WX-1:0] wide_idx;
  logic [255:0] wide_wdata, wide_rdata;
  logic         wide_stall;
  logic         rnd_valid;
  logic [255:0] rnd_data, urnd_data;
  logic         rnd_ack, rnd_prefetch, illegal;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [7:0]   m_flags;
  logic [255:0] m_mod, m_acc;

  always #2 clk = ~clk;

  bnsr_bank #(.WIDX_W(WX)) i_bnsr_bank (
    .clk_i(clk), .rst_ni(rst_n), .op_start_i(op_start),
    .csr_req_i(csr_req), .csr_op_i(csr_op), .csr_addr_i(csr_addr),
    .csr_wdata_i(csr_wdata), .csr_rdata_o(csr_rdata), .csr_stall_o(csr_stall),
    .wide_req_i(wide_req), .wide_we_i(wide_we), .wide_idx_i(wide_idx),
    .wide_wdata_i(wide_wdata), .wide_rdata_o(wide_rdata), .wide_stall_o(wide_stall),
    .rnd_valid_i(rnd_valid), .rnd_data_i(rnd_data), .urnd_data_i(urnd_data),
    .rnd_ack_o(rnd_ack), .rnd_prefetch_o(rnd_prefetch), .illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_legal(input logic [11:0] a);
    return a == 12'h7C0 || a == 12'h7C1 || a == 12'h7C8 ||
           (a >= 12'h7D0 && a <= 12'h7D8) || a == 12'hFC0 || a == 12'hFC1;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h7C0) return {28'h0, m_flags[3:0]};
    if (a == 12'h7C1) return {28'h0, m_flags[7:4]};
    if (a == 12'h7C8) return {24'h0, m_flags};
    if (a >= 12'h7D0 && a <= 12'h7D7) return m_mod[32*int'(a[2:0]) +: 32];
    if (a == 12'hFC0) return rnd_data[31:0];
    if (a == 12'hFC1) return urnd_data[31:0];
    return 32'h0;
  endfunction

  function automatic logic [255:0] m_wread(input logic [WX-1:0] i);
    case (i)
      0: return m_mod;
      1: return rnd_data;
      2: return m_acc;
      3: return urnd_data;
      default: return '0;
    endcase
  endfunction

  // narrow access, assumes rnd_valid high or address is not the queued source
  task automatic csr_acc(input logic [11:0] a, input bit op, input logic [31:0] wd, input string tag);
    logic [31:0] old, nw;
    csr_req = 1; csr_addr = a; csr_op = op; csr_wdata = wd;
    #1;
    old = m_read(a);
    chk(tag, csr_rdata, old);
    chk("R8 narrow stall", csr_stall, 0);
    chk("R8/R9 ack", rnd_ack, a == 12'hFC0);
    nw = op ? (old | wd) : wd;
    @(posedge clk);
    if (a == 12'h7C0) m_flags[3:0] = nw[3:0];
    else if (a == 12'h7C1) m_flags[7:4] = nw[3:0];
    else if (a == 12'h7C8) m_flags = nw[7:0];
    else if (a >= 12'h7D0 && a <= 12'h7D7) m_mod[32*int'(a[2:0]) +: 32] = nw;
    @(negedge clk);
    csr_req = 0;
    chk("R10 narrow illegal", illegal, !m_legal(a));
    chk("R7 refill pulse", rnd_prefetch, a == 12'h7D8);
  endtask

  task automatic wide_acc(input logic [WX-1:0] i, input bit we, input logic [255:0] wd, input string tag);
    wide_req = 1; wide_idx = i; wide_we = we; wide_wdata = wd;
    #1;
    chk(tag, wide_rdata, m_wread(i));
    chk("R8 wide stall", wide_stall, 0);
    chk("R8/R9 wide ack", rnd_ack, (i == 1) && !we);
    @(posedge clk);
    if (we && i == 0) m_mod = wd;
    if (we && i == 2) m_acc = wd;
    @(negedge clk);
    wide_req = 0;
    chk("R10 wide illegal", illegal, i > 3);
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [255:0] v;
    logic [11:0]  ad;
    int unsigned  seed;
    seed = $urandom(32'd5150);
    rst_n = 0; op_start = 0; csr_req = 0; csr_op = 0; csr_addr = 0; csr_wdata = 0;
    wide_req = 0; wide_we = 0; wide_idx = 0; wide_wdata = 0;
    rnd_valid = 1; rnd_data = 256'hA5; urnd_data = 256'h5A;
    m_flags = 0; m_mod = 0; m_acc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    wide_acc(0, 0, 0, "R1 reset MOD");
    wide_acc(2, 0, 0, "R1 reset ACC");
    csr_acc(12'h7C8, 1, 0, "R1 reset flags");

    // R5 wide read/write
    v = rnd256(); wide_acc(0, 1, v, "R5 MOD write");
    wide_acc(0, 0, 0, "R5 MOD readback");
    v = rnd256(); wide_acc(2, 1, v, "R5 ACC write");
    wide_acc(2, 0, 0, "R5 ACC readback");

    // R3 slice aliasing, R2 OR and replace
    csr_acc(12'h7D3, 0, 32'hDEADBEEF, "R3 slice 3 write");
    wide_acc(0, 0, 0, "R3 wide view after slice write");
    csr_acc(12'h7D5, 1, 32'h0F0F0000, "R2 OR slice 5");
    csr_acc(12'h7D5, 0, 32'h12345678, "R2 replace returns old");
    csr_acc(12'h7D7, 0, 32'h0, "R3 top slice");
    csr_acc(12'h7D5, 1, 32'h0, "R2 readback");

    // R4 flag views
    csr_acc(12'h7C0, 0, 32'hFFFFFFFA, "R4 group0 write");
    csr_acc(12'h7C1, 0, 32'h00000005, "R4 group1 write");
    csr_acc(12'h7C8, 0, 32'h123456C3, "R4 joint view");
    csr_acc(12'h7C1, 1, 32'h1, "R4 group1 after joint");
    csr_acc(12'h7C0, 0, 32'h0, "R4 group0 after joint");
    csr_acc(12'h7C8, 1, 32'h0, "R4 joint readback");

    // R6 read-only discards
    csr_acc(12'hFC0, 0, 32'hFFFFFFFF, "R6 write queued source");
    csr_acc(12'hFC1, 1, 32'hFFFFFFFF, "R6 write fast source");
    wide_acc(1, 1, '1, "R6 wide write idx1");
    wide_acc(3, 1, '1, "R6 wide write idx3");
    wide_acc(0, 0, 0, "R6 MOD unchanged");
    wide_acc(2, 0, 0, "R6 ACC unchanged");
    csr_acc(12'h7C8, 1, 0, "R6 flags unchanged");

    // R7 refill
    csr_acc(12'h7D8, 0, 32'hFFFFFFFF, "R7 refill reads zero");
    @(negedge clk);
    chk("R7 refill single cycle", rnd_prefetch, 0);

    // R8 stall then release, narrow
    rnd_valid = 0; rnd_data = rnd256();
    csr_req = 1; csr_addr = 12'hFC0; csr_op = 0; csr_wdata = 0;
    #1;
    chk("R8 narrow stall high", csr_stall, 1);
    chk("R8 no ack in stall", rnd_ack, 0);
    @(negedge clk);
    chk("R8 narrow stall held", csr_stall, 1);
    rnd_valid = 1; #1;
    chk("R8 narrow release", csr_stall, 0);
    chk("R8 narrow data", csr_rdata, rnd_data[31:0]);
    chk("R8 ack on release", rnd_ack, 1);
    @(negedge clk); csr_req = 0;
    // R8 wide
    rnd_valid = 0; rnd_data = rnd256();
    wide_req = 1; wide_we = 0; wide_idx = 1;
    #1;
    chk("R8 wide stall high", wide_stall, 1);
    chk("R8 wide no ack", rnd_ack, 0);
    @(negedge clk);
    rnd_valid = 1; #1;
    chk("R8 wide data", wide_rdata, rnd_data);
    chk("R8 wide ack", rnd_ack, 1);
    @(negedge clk); wide_req = 0;

    // R9 fast source never stalls
    rnd_valid = 0; urnd_data = rnd256();
    csr_acc(12'hFC1, 0, 0, "R9 narrow fast source");
    wide_acc(3, 0, 0, "R9 wide fast source");
    rnd_valid = 1;

    // R10 unmapped
    csr_acc(12'h123, 0, 32'hFFFF, "R10 unmapped narrow read");
    csr_acc(12'h7C2, 0, 32'hFFFF, "R10 gap address");
    wide_acc(5, 1, '1, "R10 wide idx5");
    wide_acc(0, 0, 0, "R10 MOD unchanged");

    // R11 both ports write MOD
    v = rnd256();
    csr_req = 1; csr_addr = 12'h7D2; csr_op = 0; csr_wdata = 32'h13579BDF;
    wide_req = 1; wide_we = 1; wide_idx = 0; wide_wdata = v;
    @(negedge clk);
    csr_req = 0; wide_req = 0; m_mod = v;
    wide_acc(0, 0, 0, "R11 wide wins");

    // R1 op start clears, wins over same-cycle write
    csr_acc(12'h7C8, 0, 32'hFF, "R1 preload flags");
    wide_acc(2, 1, rnd256(), "R1 preload ACC");
    op_start = 1;
    wide_req = 1; wide_we = 1; wide_idx = 0; wide_wdata = '1;
    @(negedge clk);
    op_start = 0; wide_req = 0;
    m_flags = 0; m_mod = 0; m_acc = 0;
    wide_acc(0, 0, 0, "R1 MOD cleared");
    wide_acc(2, 0, 0, "R1 ACC cleared");
    csr_acc(12'h7C8, 1, 0, "R1 flags cleared");

    // random phase
    for (int n = 0; n < 400; n++) begin
      rnd_data = rnd256(); urnd_data = rnd256();
      if ($urandom_range(1, 0) == 1) begin
        case ($urandom_range(4, 0))
          0: ad = 12'h7C0 + 12'($urandom_range(1, 0));
          1: ad = 12'h7C8;
          2: ad = 12'h7D0 + 12'($urandom_range(8, 0));
          3: ad = 12'hFC0 + 12'($urandom_range(1, 0));
          default: ad = 12'($urandom);
        endcase
        csr_acc(ad, 1'($urandom), $urandom, "R2 random narrow");
      end else begin
        wide_acc(WX'($urandom), 1'($urandom), rnd256(), "R5 random wide");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule